// File: doc/BRIEF.md
# Peripheral clock-enable control register

This block is a single 32-bit memory-mapped control register that gates the clocks of several peripherals hanging off a secondary peripheral bus. Software reaches it through a simple slave port: select, address, write flag, write data with per-byte strobes, read data and a ready signal. The register's enable bits drive one clock-enable output per peripheral. Those outputs feed clock-gating cells that lie outside this block.

Most enable bits are ordinary read/write bits. The security-block enable is different: software can only set it, and a hardware clear pulse is the only thing that returns it to zero. Any access, read or write, stalls with ready low while the bridge reports that a transfer on the gated bus is still in progress. The access completes in the first cycle in which the bridge is no longer busy.

Top module: `pcke_ctrl`

## Requirements
- R1: After reset the register holds 0x0000_0000, every enable output is 0 and a read at offset 0x34 returns 0.
- R2: Only the full address 0x34 selects the register. A write to any other address leaves the register unchanged, and a read at any other address returns 0.
- R3: Each byte lane (lane n covers bits 8n+7..8n) is written only when wstrb[n] is 1. Byte, half-word and word writes are all accepted.
- R4: Bits 22 (debug), 14 (serial port), 12 (SPI), 9 (ADC), 5 (timer B), 2 (timer A) and 0 (system control) are read/write. A write of 1 sets such a bit and a write of 0 clears it.
- R5: Bit 7 (security-block enable) is set by a write of 1. A write of 0 to bit 7 has no effect.
- R6: A high `sec_hw_clr` clears bit 7 at the next clock edge. This also happens when a write setting bit 7 completes in the same cycle.
- R7: All other bits (31:23, 21:15, 13, 11:10, 8, 6, 4:3, 1) are reserved. They always read 0, and writes do not change them.
- R8: `ready` is low while `sel` and `bus_busy` are both high, and high otherwise. A write takes effect only in a cycle where `ready` is high.
- R9: Each enable output equals its register bit. It changes on the clock edge that completes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access request |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane write strobes |
| bus_busy | input | 1 | Bridge reports a transfer in progress on the gated bus |
| sec_hw_clr | input | 1 | Hardware clear of the security-block enable |
| rdata | output | 32 | Read data |
| ready | output | 1 | Access completes this cycle |
| clk_en_dbg | output | 1 | Debug clock enable (bit 22) |
| clk_en_uart | output | 1 | Serial port clock enable (bit 14) |
| clk_en_spi | output | 1 | SPI clock enable (bit 12) |
| clk_en_adc | output | 1 | ADC clock enable (bit 9) |
| clk_en_sec | output | 1 | Security-block clock enable (bit 7) |
| clk_en_tmr_b | output | 1 | Timer B clock enable (bit 5) |
| clk_en_tmr_a | output | 1 | Timer A clock enable (bit 2) |
| clk_en_sysctl | output | 1 | System control clock enable (bit 0) |

## Verification
The first write is an all-ones word. It separates the writable bits from the reserved ones. An all-zeros word written next shows that bit 7 survives a zero write while the read/write bits clear. Single-lane and half-word writes with opposite data patterns show that strobes steer only their own lane. A write to a neighbouring address, a write held off by the bridge-busy signal, and a set of bit 7 that collides with the hardware clear each isolate one path that could corrupt the register.

// File: rtl/pcke_pkg.sv
package pcke_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    // Bit positions of the enables (decoded by the clock-gating logic)
    localparam int unsigned B_DBG    = 22;
    localparam int unsigned B_UART   = 14;
    localparam int unsigned B_SPI    = 12;
    localparam int unsigned B_ADC    = 9;
    localparam int unsigned B_SEC    = 7;
    localparam int unsigned B_TMR_B  = 5;
    localparam int unsigned B_TMR_A  = 2;
    localparam int unsigned B_SYSCTL = 0;

    localparam logic [DATA_W-1:0] RW_MASK_DEF  = 32'h0040_5225;
    localparam logic [DATA_W-1:0] SET_MASK_DEF = 32'h0000_0080;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } pcke_state_t;
endpackage

// File: rtl/pcke_stall.sv
module pcke_stall (
    input  logic sel,
    input  logic write,
    input  logic addr_hit,
    input  logic bus_busy,
    output logic ready,
    output logic wr_fire
);
    always_comb begin
        ready   = !(sel && bus_busy);
        wr_fire = sel && write && addr_hit && !bus_busy;
    end
endmodule

// File: rtl/pcke_lane_merge.sv
module pcke_lane_merge #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wstrb,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = wstrb[g] ? wdata[8*g +: 8] : cur[8*g +: 8];
    end
endmodule

// File: rtl/pcke_bitctl.sv
module pcke_bitctl #(
    parameter int unsigned       DATA_W   = 32,
    parameter logic [DATA_W-1:0] RW_MASK  = 32'h0040_5225,
    parameter logic [DATA_W-1:0] SET_MASK = 32'h0000_0080
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] merged,
    input  logic              wr_fire,
    input  logic              hw_clr,
    output logic [DATA_W-1:0] nxt
);
    localparam logic [DATA_W-1:0] LIVE = RW_MASK | SET_MASK;

    logic unused_resv;
    assign unused_resv = ^(merged & ~LIVE);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (SET_MASK[b]) begin : g_set
            // hardware clear takes priority over a software set
            assign nxt[b] = hw_clr ? 1'b0 : (cur[b] | (wr_fire & merged[b]));
        end else if (RW_MASK[b]) begin : g_rw
            assign nxt[b] = wr_fire ? merged[b] : cur[b];
        end else begin : g_resv
            assign nxt[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pcke_ctrl.sv
module pcke_ctrl
    import pcke_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_OFS  = 8'h34,
    parameter logic [31:0]       RW_MASK  = RW_MASK_DEF,
    parameter logic [31:0]       SET_MASK = SET_MASK_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              bus_busy,
    input  logic              sec_hw_clr,
    output logic [31:0]       rdata,
    output logic              ready,
    output logic              clk_en_dbg,
    output logic              clk_en_uart,
    output logic              clk_en_spi,
    output logic              clk_en_adc,
    output logic              clk_en_sec,
    output logic              clk_en_tmr_b,
    output logic              clk_en_tmr_a,
    output logic              clk_en_sysctl
);
    pcke_state_t state_d, state_q;
    logic              addr_hit;
    logic              wr_fire;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] nxt_bits;
    logic [DATA_W-1:0] reg_bits;

    assign addr_hit = (addr == REG_OFS);
    assign reg_bits = state_q.bits;

    pcke_stall stall_i (
        .sel      (sel),
        .write    (write),
        .addr_hit (addr_hit),
        .bus_busy (bus_busy),
        .ready    (ready),
        .wr_fire  (wr_fire)
    );

    pcke_lane_merge #(.DATA_W(DATA_W)) merge_i (
        .cur    (reg_bits),
        .wdata  (wdata),
        .wstrb  (wstrb),
        .merged (merged)
    );

    pcke_bitctl #(.DATA_W(DATA_W), .RW_MASK(RW_MASK), .SET_MASK(SET_MASK)) bitctl_i (
        .cur     (reg_bits),
        .merged  (merged),
        .wr_fire (wr_fire),
        .hw_clr  (sec_hw_clr),
        .nxt     (nxt_bits)
    );

    always_comb begin
        state_d      = state_q;
        state_d.bits = nxt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = (sel && !write && addr_hit && !bus_busy) ? reg_bits : '0;

    assign clk_en_dbg    = reg_bits[B_DBG];
    assign clk_en_uart   = reg_bits[B_UART];
    assign clk_en_spi    = reg_bits[B_SPI];
    assign clk_en_adc    = reg_bits[B_ADC];
    assign clk_en_sec    = reg_bits[B_SEC];
    assign clk_en_tmr_b  = reg_bits[B_TMR_B];
    assign clk_en_tmr_a  = reg_bits[B_TMR_A];
    assign clk_en_sysctl = reg_bits[B_SYSCTL];
endmodule

// File: rtl/pcke_ctrl_chk.sv
module pcke_ctrl_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_OFS  = 8'h34,
    parameter logic [31:0]       RW_MASK  = 32'h0040_5225,
    parameter logic [31:0]       SET_MASK = 32'h0000_0080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              write,
    input logic [ADDR_W-1:0] addr,
    input logic              bus_busy,
    input logic              sec_hw_clr,
    input logic              ready,
    input logic [31:0]       reg_bits,
    input logic              clk_en_sec
);
    // R7: reserved bits never become 1
    p_resv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_bits & ~(RW_MASK | SET_MASK)) == 32'h0);

    // R8: a busy bridge stalls the access
    p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && bus_busy) |-> !ready);

    // R8: a stalled write does not touch the read/write bits
    p_no_stalled_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && write && bus_busy) |=> $stable(reg_bits & RW_MASK));

    // R2: writes elsewhere leave the register alone
    p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && write && addr != REG_OFS) |=> $stable(reg_bits & RW_MASK));

    // R6: hardware clear always wins
    p_hw_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_hw_clr |=> !clk_en_sec);

    // R5: once set, only hardware clears the security enable
    p_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_sec && !sec_hw_clr) |=> clk_en_sec);
endmodule

bind pcke_ctrl pcke_ctrl_chk #(
    .ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .RW_MASK(RW_MASK), .SET_MASK(SET_MASK)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .write      (write),
    .addr       (addr),
    .bus_busy   (bus_busy),
    .sec_hw_clr (sec_hw_clr),
    .ready      (ready),
    .reg_bits   (reg_bits),
    .clk_en_sec (clk_en_sec)
);

// File: tb/pcke_ctrl_tb.sv
module pcke_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, write = 1'b0, bus_busy = 1'b0, sec_hw_clr = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [3:0]  wstrb = 4'h0;
    logic [31:0] rdata;
    logic        ready;
    logic        e_dbg, e_uart, e_spi, e_adc, e_sec, e_tb, e_ta, e_sys;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    pcke_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .write(write), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .bus_busy(bus_busy), .sec_hw_clr(sec_hw_clr),
        .rdata(rdata), .ready(ready),
        .clk_en_dbg(e_dbg), .clk_en_uart(e_uart), .clk_en_spi(e_spi), .clk_en_adc(e_adc),
        .clk_en_sec(e_sec), .clk_en_tmr_b(e_tb), .clk_en_tmr_a(e_ta), .clk_en_sysctl(e_sys)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare the enable outputs with the bits of an expected register value
    task automatic chk_outs(input logic [31:0] exp, input string req);
        logic [7:0] a, e;
        a = {e_dbg, e_uart, e_spi, e_adc, e_sec, e_tb, e_ta, e_sys};
        e = {exp[22], exp[14], exp[12], exp[9], exp[7], exp[5], exp[2], exp[0]};
        chk(a == e, req, {24'h0, a}, {24'h0, e});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        sel = 1'b1; write = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        sel = 1'b0; write = 1'b0; wstrb = 4'h0;
        #1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        sel = 1'b1; write = 1'b0; addr = a;
        #1;
        chk(rdata === exp, req, rdata, exp);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk_outs(32'h0, "R1 outputs after reset");
        rd_chk(8'h34, 32'h0, "R1 read after reset");
    endtask

    task automatic t_full_words;
        wr(8'h34, 32'hFFFF_FFFF, 4'hF);
        chk_outs(32'h0040_52A5, "R9 outputs after all-ones write");
        rd_chk(8'h34, 32'h0040_52A5, "R7 reserved bits read zero");
        wr(8'h34, 32'h0, 4'hF);
        chk_outs(32'h0000_0080, "R5 zero write keeps bit 7");
        rd_chk(8'h34, 32'h0000_0080, "R4 rw bits cleared");
    endtask

    task automatic t_hw_clear;
        @(negedge clk); sec_hw_clr = 1'b1;
        @(negedge clk); sec_hw_clr = 1'b0;
        #1;
        chk_outs(32'h0, "R6 hardware clear");
    endtask

    task automatic t_lanes;
        wr(8'h34, 32'hFFFF_FFFF, 4'b0001);
        rd_chk(8'h34, 32'h0000_00A5, "R3 lane 0 only");
        wr(8'h34, 32'hFFFF_FFFF, 4'b0100);
        rd_chk(8'h34, 32'h0040_00A5, "R3 lane 2 only");
        wr(8'h34, 32'h0, 4'b1100);
        rd_chk(8'h34, 32'h0000_00A5, "R3 upper half-word clear");
        wr(8'h34, 32'hFFFF_FFFF, 4'b0010);
        rd_chk(8'h34, 32'h0000_52A5, "R4 lane 1 bits 14 12 9");
        chk_outs(32'h0000_52A5, "R9 lane outputs");
    endtask

    task automatic t_other_addr;
        wr(8'h30, 32'h0, 4'hF);
        wr(8'h35, 32'h0, 4'hF);
        chk_outs(32'h0000_52A5, "R2 write elsewhere ignored");
        rd_chk(8'h30, 32'h0, "R2 read elsewhere zero");
    endtask

    task automatic t_busy;
        @(negedge clk);
        bus_busy = 1'b1; sel = 1'b1; write = 1'b1; addr = 8'h34; wdata = 32'h0; wstrb = 4'hF;
        #1;
        chk(ready == 1'b0, "R8 ready low while busy", {31'h0, ready}, 32'h0);
        @(negedge clk);
        #1;
        chk_outs(32'h0000_52A5, "R8 stalled write not applied");
        bus_busy = 1'b0;
        #1;
        chk(ready == 1'b1, "R8 ready after busy ends", {31'h0, ready}, 32'h1);
        @(negedge clk);
        sel = 1'b0; write = 1'b0; wstrb = 4'h0;
        #1;
        chk_outs(32'h0000_0080, "R8 write completes after stall");
    endtask

    task automatic t_collide;
        @(negedge clk);
        sel = 1'b1; write = 1'b1; addr = 8'h34; wdata = 32'h0000_0081; wstrb = 4'h1; sec_hw_clr = 1'b1;
        @(negedge clk);
        sel = 1'b0; write = 1'b0; wstrb = 4'h0; sec_hw_clr = 1'b0;
        #1;
        chk_outs(32'h0000_0001, "R6 clear wins over same-cycle set");
        wr(8'h34, 32'h0000_0080, 4'h1);
        chk_outs(32'h0000_0080, "R5 write one sets bit 7");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_words();
        t_hw_clear();
        t_lanes();
        t_other_addr();
        t_busy();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule